// File: doc/BRIEF.md
# Two-Packet Stream Splitter and Realigner

This block sits on a 256-bit receive stream in which one beat may carry the end of one packet and the start of the next. A 2-bit start vector and a 2-bit end vector mark which 128-bit half holds each boundary. The input counts empty space in 64-bit units and tags each request with a one-hot window-hit byte. The block turns that stream into one where every beat belongs to exactly one packet. Every packet begins at output bit 0. Empty space on the output is counted in 32-bit units, and the window hit becomes a 3-bit binary code.

Input beats land in a small skid store. That store covers the two-cycle gap between the block dropping its ready and the sender seeing it. A half-by-half packer then pairs consecutive 128-bit halves of each packet into output beats. When an input beat yields two output beats, the block emits them over two handshakes. The lower-half result always goes out first. The output side uses a plain valid/ready handshake with zero ready latency.

Top module: `adapterTop`

## Requirements
- R1: `inReady` is high exactly while at most DEPTH-1-LATENCY beats (1 with defaults) are stored. Every beat presented with `inValid` is accepted, including beats that arrive up to LATENCY cycles after `inReady` falls, and none is lost.
- R2: Bit 0 of `inSop` or `inEop` marks a packet boundary in `inData[127:0]`, and bit 1 marks one in `inData[255:128]`. On the output, `outSop` is set on the first beat of each packet and `outEop` on its last.
- R3: A packet that starts in the lower half is passed through with its input beats unchanged. The only exception is that unused lanes of a final beat that ends in the lower half are zero.
- R4: A packet that starts in the upper half is shifted down. Output beat k carries packet half 2k in bits 127:0 and half 2k+1 in bits 255:128, and this alignment holds until the packet's end.
- R5: A beat with an end in the lower half and a start in the upper half is split. The ending packet is closed, and the new packet is realigned to start at output bit 0.
- R6: On an end beat, `outEmpty` = 2×q, plus 4 when the packet finishes in the lower output half. Here q is 1 when `inEmpty` is nonzero and 0 otherwise, since an ending half holds at most one empty qword. When a beat carries two ends, `inEmpty` belongs to the upper one and the lower packet fills its half. Non-end beats have `outEmpty` = 0.
- R7: `outBar` is taken from `inBar` on start beats only and is held for every output beat of that packet. Set bits 0..5 map to codes 0..5, and the lowest such bit wins. Bit 6 alone among 0..6 maps to 7. Bit 7 set, or no bit set, maps to 6.
- R8: While `outValid` is high and `outReady` is low, every output stays unchanged, and no beat is dropped or repeated under backpressure.
- R9: Halves outside any packet produce no output, and their data, empty and window-hit values have no effect.
- R10: After reset, `outValid` is low and `inReady` is high.
- R11: When one input beat completes two output beats, the result from the lower half is presented first and the one from the upper half after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Input beat present (ready latency LATENCY) |
| inReady | output | 1 | Room for more beats |
| inData | input | DATA_W | Input beat data |
| inSop | input | 2 | Packet start per half |
| inEop | input | 2 | Packet end per half |
| inEmpty | input | 2 | Empty qwords of the ending half |
| inBar | input | 8 | One-hot window hit, read on start beats |
| outValid | output | 1 | Output beat present |
| outReady | input | 1 | Downstream accepts the beat |
| outData | output | DATA_W | Realigned beat data |
| outSop | output | 1 | First beat of a packet |
| outEop | output | 1 | Last beat of a packet |
| outEmpty | output | 3 | Empty dwords on the last beat |
| outBar | output | 3 | Binary window code |

## Verification
Several checks run on every cycle. The output must hold still while stalled, and non-end beats must report zero empty. A beat ending in the lower output half must carry zeroed upper lanes. Starts and ends must alternate on the output, and input beats may only arrive within the ready-latency window. The bench's scenarios have to show everything else. That covers the data realignment across packets started in either half, splitting of mixed beats and their order, the empty arithmetic, and each window-hit code. It also covers the loss-free absorption of late beats under heavy backpressure and the silent dropping of idle halves.

// File: rtl/adapterPkg.sv
package adapterPkg;

  localparam int BAR_HIT_W = 8;

  typedef struct packed {
    logic       inPkt;
    logic       holdValid;
    logic       sopPend;
    logic [2:0] bar;
  } packState_t;

  typedef struct packed {
    packState_t nxt;
    logic       emit;
    logic       combine;
    logic       loadHold;
    logic       sop;
    logic       eop;
    logic [2:0] empty;
    logic [2:0] bar;
  } halfStep_t;

  typedef struct packed {
    logic push;
    logic pop;
    logic outUpper;
    logic outCombine;
    logic combineLow;
    logic holdLoad;
    logic holdUpper;
  } dpStrobe_t;

  // One-hot window hit to binary code; bit 7 or nothing set gives 6.
  function automatic logic [2:0] barToCode(logic [BAR_HIT_W-1:0] hit);
    logic [2:0] code;
    code = 3'd6;
    if (!hit[7]) begin
      if (hit[6]) code = 3'd7;
      for (int i = 5; i >= 0; i--) begin
        if (hit[i]) code = 3'(i);
      end
    end
    return code;
  endfunction

  // Advance the packer by one 128-bit half.
  function automatic halfStep_t stepHalf(packState_t cur, logic sop, logic eop,
                                         logic emptyQw, logic [2:0] newBar);
    halfStep_t r;
    logic active;
    logic hv;
    r       = '0;
    r.nxt   = cur;
    active  = sop | cur.inPkt;
    hv      = cur.holdValid & ~sop;
    if (sop) begin
      r.nxt.bar     = newBar;
      r.nxt.sopPend = 1'b1;
    end
    r.emit     = active & (hv | eop);
    r.combine  = active & hv;
    r.loadHold = active & ~hv & ~eop;
    r.sop      = r.nxt.sopPend;
    r.eop      = active & eop;
    r.bar      = r.nxt.bar;
    if (active & eop) r.empty = {1'b0, emptyQw, 1'b0} + (hv ? 3'd0 : 3'd4);
    if (active) begin
      r.nxt.holdValid = r.loadHold;
      r.nxt.inPkt     = ~eop;
      if (r.emit) r.nxt.sopPend = 1'b0;
    end
    return r;
  endfunction

endpackage

// File: rtl/adapterDatapath.sv
module adapterDatapath
  import adapterPkg::*;
#(
  parameter int DATA_W = 256,
  parameter int DEPTH  = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  dpStrobe_t            stb,
  input  logic [DATA_W-1:0]    inData,
  input  logic [1:0]           inSop,
  input  logic [1:0]           inEop,
  input  logic [1:0]           inEmpty,
  input  logic [BAR_HIT_W-1:0] inBar,
  output logic [1:0]           headSop,
  output logic [1:0]           headEop,
  output logic                 headEmptyQw,
  output logic [2:0]           headBar,
  output logic [DATA_W-1:0]    outData
);

  localparam int HALF_W = DATA_W / 2;
  localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DATA_W-1:0] memData  [DEPTH];
  logic [1:0]        memSop   [DEPTH];
  logic [1:0]        memEop   [DEPTH];
  logic              memEmpty [DEPTH];
  logic [2:0]        memBar   [DEPTH];

  logic [PTR_W-1:0]  wrPtr;
  logic [PTR_W-1:0]  rdPtr;
  logic [HALF_W-1:0] holdReg;
  logic [DATA_W-1:0] headData;
  logic [HALF_W-1:0] pickHalf;
  logic [HALF_W-1:0] lowPart;

  function automatic logic [PTR_W-1:0] bump(logic [PTR_W-1:0] p);
    return (int'(p) == DEPTH - 1) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (stb.push) wrPtr <= bump(wrPtr);
      if (stb.pop)  rdPtr <= bump(rdPtr);
    end
  end

  always_ff @(posedge clk) begin
    if (stb.push) begin
      memData[wrPtr]  <= inData;
      memSop[wrPtr]   <= inSop;
      memEop[wrPtr]   <= inEop;
      memEmpty[wrPtr] <= |inEmpty;
      memBar[wrPtr]   <= barToCode(inBar);
    end
  end

  assign headData    = memData[rdPtr];
  assign headSop     = memSop[rdPtr];
  assign headEop     = memEop[rdPtr];
  assign headEmptyQw = memEmpty[rdPtr];
  assign headBar     = memBar[rdPtr];

  always_ff @(posedge clk) begin
    if (rst) begin
      holdReg <= '0;
    end else if (stb.holdLoad) begin
      holdReg <= stb.holdUpper ? headData[DATA_W-1:HALF_W] : headData[HALF_W-1:0];
    end
  end

  always_comb begin
    pickHalf = stb.outUpper ? headData[DATA_W-1:HALF_W] : headData[HALF_W-1:0];
    lowPart  = stb.combineLow ? headData[HALF_W-1:0] : holdReg;
    outData  = stb.outCombine ? {pickHalf, lowPart} : {{HALF_W{1'b0}}, pickHalf};
  end

endmodule

// File: rtl/adapterControl.sv
module adapterControl
  import adapterPkg::*;
#(
  parameter int DEPTH   = 4,
  parameter int LATENCY = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       inValid,
  output logic       inReady,
  output logic       outValid,
  input  logic       outReady,
  output logic       outSop,
  output logic       outEop,
  output logic [2:0] outEmpty,
  output logic [2:0] outBar,
  input  logic [1:0] headSop,
  input  logic [1:0] headEop,
  input  logic       headEmptyQw,
  input  logic [2:0] headBar,
  output dpStrobe_t  stb
);

  localparam int CNT_W       = $clog2(DEPTH + 1);
  localparam int READY_LIMIT = DEPTH - 1 - LATENCY;

  logic [CNT_W-1:0] count;
  logic             phase;
  packState_t       curState;
  packState_t       midState;
  halfStep_t        lowStep;
  halfStep_t        upStep;
  halfStep_t        pick;
  logic             headValid;
  logic             lowEmptyQw;
  logic             emitLow;
  logic             emitUp;
  logic             twoOut;
  logic             fire;
  logic             advance;

  assign headValid  = (count != '0);
  assign inReady    = (count <= CNT_W'(READY_LIMIT));
  assign lowEmptyQw = headEop[0] & ~headEop[1] & headEmptyQw;

  always_comb begin
    lowStep  = stepHalf(curState, headSop[0], headEop[0], lowEmptyQw, headBar);
    midState = phase ? curState : lowStep.nxt;
    upStep   = stepHalf(midState, headSop[1], headEop[1], headEmptyQw, headBar);

    emitLow  = headValid & ~phase & lowStep.emit;
    emitUp   = headValid & upStep.emit;
    twoOut   = emitLow & emitUp;
    pick     = emitLow ? lowStep : upStep;

    outValid = emitLow | emitUp;
    outSop   = pick.sop;
    outEop   = pick.eop;
    outEmpty = pick.empty;
    outBar   = pick.bar;

    fire     = outValid & outReady;
    advance  = headValid & (~outValid | fire);

    stb.push       = inValid;
    stb.pop        = advance & ~twoOut;
    stb.outUpper   = ~emitLow;
    stb.outCombine = pick.combine;
    stb.combineLow = ~emitLow & ~phase & lowStep.loadHold;
    stb.holdLoad   = stb.pop & (upStep.loadHold | (~phase & lowStep.loadHold));
    stb.holdUpper  = upStep.loadHold;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count    <= '0;
      phase    <= 1'b0;
      curState <= '0;
    end else begin
      count <= count + CNT_W'(stb.push) - CNT_W'(stb.pop);
      if (advance) begin
        phase    <= twoOut;
        curState <= twoOut ? lowStep.nxt : upStep.nxt;
      end
    end
  end

endmodule

// File: rtl/adapterTop.sv
module adapterTop
  import adapterPkg::*;
#(
  parameter int DATA_W  = 256,
  parameter int DEPTH   = 4,
  parameter int LATENCY = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 inValid,
  output logic                 inReady,
  input  logic [DATA_W-1:0]    inData,
  input  logic [1:0]           inSop,
  input  logic [1:0]           inEop,
  input  logic [1:0]           inEmpty,
  input  logic [BAR_HIT_W-1:0] inBar,
  output logic                 outValid,
  input  logic                 outReady,
  output logic [DATA_W-1:0]    outData,
  output logic                 outSop,
  output logic                 outEop,
  output logic [2:0]           outEmpty,
  output logic [2:0]           outBar
);

  dpStrobe_t  stb;
  logic [1:0] headSop;
  logic [1:0] headEop;
  logic       headEmptyQw;
  logic [2:0] headBar;

  adapterControl #(.DEPTH(DEPTH), .LATENCY(LATENCY)) uCtrl (
    .clk(clk), .rst(rst), .inValid(inValid), .inReady(inReady),
    .outValid(outValid), .outReady(outReady), .outSop(outSop), .outEop(outEop),
    .outEmpty(outEmpty), .outBar(outBar), .headSop(headSop), .headEop(headEop),
    .headEmptyQw(headEmptyQw), .headBar(headBar), .stb(stb)
  );

  adapterDatapath #(.DATA_W(DATA_W), .DEPTH(DEPTH)) uData (
    .clk(clk), .rst(rst), .stb(stb), .inData(inData), .inSop(inSop),
    .inEop(inEop), .inEmpty(inEmpty), .inBar(inBar), .headSop(headSop),
    .headEop(headEop), .headEmptyQw(headEmptyQw), .headBar(headBar),
    .outData(outData)
  );

endmodule

// File: rtl/adapterTopChecker.sv
module adapterTopChecker #(
  parameter int DATA_W = 256
) (
  input logic              clk,
  input logic              rst,
  input logic              inValid,
  input logic              inReady,
  input logic              outValid,
  input logic              outReady,
  input logic              outSop,
  input logic              outEop,
  input logic [2:0]        outEmpty,
  input logic [2:0]        outBar,
  input logic [DATA_W-1:0] outData
);

  logic [1:0] warm;
  logic       openPkt;

  always_ff @(posedge clk) begin
    if (rst) begin
      warm    <= '0;
      openPkt <= 1'b0;
    end else begin
      if (warm != 2'd3) warm <= warm + 2'd1;
      if (outValid && outReady) begin
        if (outEop)      openPkt <= 1'b0;
        else if (outSop) openPkt <= 1'b1;
      end
    end
  end

  // R1: beats only arrive within the ready-latency window
  a_r1_latency_window: assert property (@(posedge clk) disable iff (rst)
    (warm >= 2'd2 && inValid) |-> $past(inReady, 2));

  // R8: a stalled output stays unchanged
  a_r8_hold_on_stall: assert property (@(posedge clk) disable iff (rst)
    (outValid && !outReady) |=> (outValid && $stable(outData) && $stable(outSop)
      && $stable(outEop) && $stable(outEmpty) && $stable(outBar)));

  // R6: only end beats report empty space
  a_r6_empty_on_end_only: assert property (@(posedge clk) disable iff (rst)
    (outValid && !outEop) |-> (outEmpty == 3'd0));

  // R3: a beat finishing in the lower output half has zero upper lanes
  a_r3_upper_lanes_zero: assert property (@(posedge clk) disable iff (rst)
    (outValid && outEop && outEmpty >= 3'd4) |-> (outData[DATA_W-1:DATA_W/2] == '0));

  // R2: starts and ends alternate on the output
  a_r2_framing: assert property (@(posedge clk) disable iff (rst)
    outValid |-> (outSop == !openPkt));

endmodule

bind adapterTop adapterTopChecker #(.DATA_W(DATA_W)) uChk (
  .clk(clk), .rst(rst), .inValid(inValid), .inReady(inReady),
  .outValid(outValid), .outReady(outReady), .outSop(outSop), .outEop(outEop),
  .outEmpty(outEmpty), .outBar(outBar), .outData(outData)
);

// File: tb/adapterTop_test.sv
`timescale 1ns/1ps
module adapterTop_test;

  localparam int DW = 256;
  localparam int HW = 128;

  typedef struct {
    logic [DW-1:0] data;
    bit            sop;
    bit            eop;
    logic [2:0]    empty;
    logic [2:0]    bar;
    string         tag;
  } expBeat_t;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          inValid = 1'b0;
  logic          inReady;
  logic [DW-1:0] inData = '0;
  logic [1:0]    inSop = '0;
  logic [1:0]    inEop = '0;
  logic [1:0]    inEmpty = '0;
  logic [7:0]    inBar = '0;
  logic          outValid;
  logic          outReady = 1'b0;
  logic [DW-1:0] outData;
  logic          outSop;
  logic          outEop;
  logic [2:0]    outEmpty;
  logic [2:0]    outBar;

  int checks = 0;
  int errors = 0;
  int rdyPct = 100;
  int readyLowSeen = 0;
  int extraBeats = 0;
  logic [1:0] rdyHist = '0;

  logic [HW-1:0] sData[$];
  bit            sSop[$];
  bit            sEop[$];
  bit            sE[$];
  logic [7:0]    sBar[$];
  expBeat_t      expQ[$];

  adapterTop uut (
    .clk(clk), .rst(rst), .inValid(inValid), .inReady(inReady), .inData(inData),
    .inSop(inSop), .inEop(inEop), .inEmpty(inEmpty), .inBar(inBar),
    .outValid(outValid), .outReady(outReady), .outData(outData), .outSop(outSop),
    .outEop(outEop), .outEmpty(outEmpty), .outBar(outBar)
  );

  always #2.5 clk = ~clk;

  always @(posedge clk) rdyHist <= {rdyHist[0], inReady};

  task automatic check(bit ok, string req, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [2:0] expectCode(logic [7:0] hit);
    if (hit[7]) return 3'd6;
    for (int i = 0; i < 6; i++) if (hit[i]) return 3'(i);
    if (hit[6]) return 3'd7;
    return 3'd6;
  endfunction

  function automatic logic [HW-1:0] randHalf();
    return {$urandom(), $urandom(), $urandom(), $urandom()};
  endfunction

  task automatic addIdle();
    sData.push_back(randHalf());
    sSop.push_back(0);
    sEop.push_back(0);
    sE.push_back(0);
    sBar.push_back(8'($urandom()));
  endtask

  task automatic addPacket(int n, bit wantUpper, logic [7:0] bar, bit e);
    logic [HW-1:0] h[$];
    int start;
    bit afterEop;
    if (wantUpper != (sData.size() % 2 == 1)) addIdle();
    if (sData.size() % 2 == 1 && sSop[sData.size()-1]) addIdle();
    if (sData.size() % 2 == 1 && n == 1 && sEop[sData.size()-1] && sE[sData.size()-1]) addIdle();
    start = sData.size();
    afterEop = (start % 2 == 1) && sEop[start-1];
    for (int k = 0; k < n; k++) begin
      h.push_back(randHalf());
      sData.push_back(h[k]);
      sSop.push_back(k == 0);
      sEop.push_back(k == n - 1);
      sE.push_back((k == n - 1) ? e : 1'b0);
      sBar.push_back(bar);
    end
    for (int b = 0; b < (n + 1) / 2; b++) begin
      expBeat_t x;
      x.data  = {(2*b+1 < n) ? h[2*b+1] : {HW{1'b0}}, h[2*b]};
      x.sop   = (b == 0);
      x.eop   = (b == (n + 1) / 2 - 1);
      x.empty = x.eop ? 3'({e, 1'b0} + ((n % 2 == 1) ? 4 : 0)) : 3'd0;
      x.bar   = expectCode(bar);
      if (afterEop) x.tag = "R5";
      else if (start % 2 == 1) x.tag = (x.eop && n >= 3 && n % 2 == 1) ? "R11" : "R4";
      else x.tag = "R3";
      expQ.push_back(x);
    end
  endtask

  task automatic driveAll(int vPct);
    int nb;
    int i;
    if (sData.size() % 2 == 1) addIdle();
    nb = sData.size() / 2;
    i = 0;
    while (i < nb) begin
      @(negedge clk);
      if (rdyHist[1] && ($urandom_range(99) < vPct)) begin
        int lo;
        int hi;
        lo = 2 * i;
        hi = 2 * i + 1;
        inValid = 1'b1;
        inData  = {sData[hi], sData[lo]};
        inSop   = {sSop[hi], sSop[lo]};
        inEop   = {sEop[hi], sEop[lo]};
        if (sEop[hi])      inEmpty = sE[hi] ? 2'($urandom_range(3, 1)) : 2'd0;
        else if (sEop[lo]) inEmpty = sE[lo] ? 2'($urandom_range(3, 1)) : 2'd0;
        else               inEmpty = 2'($urandom());
        if (sSop[hi])      inBar = sBar[hi];
        else if (sSop[lo]) inBar = sBar[lo];
        else               inBar = 8'($urandom());
        i++;
      end else begin
        inValid = 1'b0;
        inData  = {randHalf(), randHalf()};
        inSop   = 2'($urandom());
        inEop   = 2'($urandom());
      end
    end
    @(negedge clk);
    inValid = 1'b0;
    sData.delete(); sSop.delete(); sEop.delete(); sE.delete(); sBar.delete();
  endtask

  task automatic waitDrain(string req);
    int n;
    n = 0;
    while (expQ.size() != 0 && n < 3000) begin
      @(negedge clk);
      n++;
    end
    repeat (20) @(negedge clk);
    check(expQ.size() == 0, req, "beats left undelivered", DW'(expQ.size()), '0);
  endtask

  // Monitor: compares each accepted output beat against the scoreboard
  always @(negedge clk) begin
    outReady = ($urandom_range(99) < rdyPct);
    if (!rst && !inReady) readyLowSeen++;
    if (!rst && outValid && outReady) begin
      if (expQ.size() == 0) begin
        extraBeats++;
      end else begin
        expBeat_t x;
        x = expQ.pop_front();
        check(outData == x.data, x.tag, "data", outData, x.data);
        check(outSop == x.sop && outEop == x.eop, "R2", "sop/eop",
              DW'({outSop, outEop}), DW'({x.sop, x.eop}));
        check(outEmpty == x.empty, "R6", "empty", DW'(outEmpty), DW'(x.empty));
        check(outBar == x.bar, "R7", "bar", DW'(outBar), DW'(x.bar));
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] bars[10];
    bars = '{8'h00, 8'h01, 8'h02, 8'h04, 8'h08, 8'h10, 8'h20, 8'h40, 8'h80, 8'h81};
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10: idle after reset
    check(outValid == 1'b0, "R10", "outValid after reset", DW'(outValid), '0);
    check(inReady == 1'b1, "R10", "inReady after reset", DW'(inReady), DW'(1));

    // R3: packets aligned to the lower half, no backpressure
    for (int n = 1; n <= 6; n++) addPacket(n, 1'b0, bars[n], n[0]);
    driveAll(100);
    waitDrain("R3");

    // R4, R5, R11: packets starting in the upper half
    for (int n = 1; n <= 6; n++) addPacket(n, 1'b1, bars[n+1], n[1]);
    addPacket(2, 1'b1, 8'h04, 1'b0);
    addPacket(3, 1'b1, 8'h08, 1'b1);
    driveAll(100);
    waitDrain("R4");

    // R7: every window-hit pattern
    for (int k = 0; k < 10; k++) addPacket(1 + k % 3, k[0], bars[k], 1'b0);
    addPacket(2, 1'b0, 8'h0C, 1'b1);
    driveAll(100);
    waitDrain("R7");

    // R1, R8, R9: mixed traffic, idle halves, heavy backpressure
    rdyPct = 30;
    readyLowSeen = 0;
    for (int k = 0; k < 40; k++) begin
      if ($urandom_range(3) == 0) addIdle();
      addPacket($urandom_range(8, 1), 1'($urandom()), bars[$urandom_range(9)], 1'($urandom()));
    end
    driveAll(80);
    rdyPct = 100;
    waitDrain("R1");
    check(readyLowSeen > 0, "R1", "inReady never dropped", DW'(readyLowSeen), DW'(1));
    check(inReady == 1'b1, "R1", "inReady after drain", DW'(inReady), DW'(1));
    // R9: idle halves and junk fields produced no extra beats
    check(extraBeats == 0, "R9", "unexpected output beats", DW'(extraBeats), '0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule